// File: doc/BRIEF.md
# Byte-Strobed Sampling Delay Control Interface

This block sits between a 16-bit processor bus and a triggered sampling delay circuit. It holds two banks of output-only parallel registers. The lower byte strobe selects one bank and the upper byte strobe selects the other, so one bus cycle can load either bank or both. A two-bit address picks a register inside the selected bank.

The bank registers feed two delay outputs, an 8-bit DAC code and a 24-bit digital delay count. Software writes the delay as one integer, and the block applies the bitwise inverse of that integer. A written zero therefore selects the longest delay.

The block also drives a processor halt. The halt starts on a trigger and ends when the analog sample has been taken, which keeps processor activity quiet while the sample is acquired.

Top module: `delay_ctl_if`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every bank register reads 0, `dac_code` is 0xFF, `dly_count` is 0xFFFFFF and `cpu_halt` is 0.
- R2: On a clock edge where `bus_sel`, `bus_wr` and `bus_lbe` are all 1, `bus_wdata[7:0]` is stored in the lower bank register chosen by `bus_addr`. The address values are 0 for port A, 1 for port B, 2 for port C and 3 for the control register.
- R3: On a clock edge where `bus_sel`, `bus_wr` and `bus_ube` are all 1, `bus_wdata[15:8]` is stored in the upper bank register chosen by `bus_addr`, with the same address encoding. The lower bank does not change.
- R4: When both byte strobes are 1 during a write, both banks are written at the same address in the same cycle.
- R5: A cycle with `bus_sel`, `bus_wr` or both byte strobes at 0 changes no register and no output.
- R6: While `bus_sel` and `bus_rd` are 1, `bus_rdata[7:0]` shows the addressed lower bank register if `bus_lbe` is 1 and 0 otherwise. `bus_rdata[15:8]` shows the addressed upper bank register if `bus_ube` is 1 and 0 otherwise. `bus_rdata` is 0 when no read is active. Read data is combinational.
- R7: `dac_code` equals the bitwise inverse of lower bank port A.
- R8: `dly_count` equals the bitwise inverse of {upper port B, upper port A, lower port B}, most significant byte first.
- R9: Control registers and port C can be written and read back, but writing them does not change `dac_code` or `dly_count`.
- R10: When `cpu_halt` is 0 and `trig_in` is 1 at a clock edge, `cpu_halt` is 1 after that edge. This holds even if `sample_done` is also 1 in that cycle.
- R11: While `cpu_halt` is 1, it stays 1 until an edge with `sample_done` at 1, and it is 0 after that edge. A `trig_in` pulse during the halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Chip select shared by both banks |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_lbe | input | 1 | Lower byte strobe, selects the lower bank |
| bus_ube | input | 1 | Upper byte strobe, selects the upper bank |
| bus_addr | input | 2 | Register select inside a bank |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| trig_in | input | 1 | Trigger pulse |
| sample_done | input | 1 | Sample-taken pulse |
| dac_code | output | 8 | Inverted DAC code |
| dly_count | output | 24 | Inverted digital delay count |
| cpu_halt | output | 1 | Processor halt |

## Verification
Some properties are checked by assertions on every cycle:
- the halt set and release rules, including holding the halt while no `sample_done` arrives;
- that idle bus cycles leave the delay outputs unchanged;
- that a write to lower port A or upper port B appears inverted on the outputs one cycle later.

Other behaviour only the bench scenarios can show:
- the full byte-lane routing of read data;
- that control and port C writes read back yet leave the delay untouched;
- that a zero write selects the maximum delay;
- that a trigger arriving during a halt is ignored.

The bench checks these against a reference model of both banks, using random bus traffic with a fixed seed.

// File: rtl/delay_ctl_pkg.sv
package delay_ctl_pkg;
    localparam int PORT_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_BANKS = 2;
    localparam int BUS_W   = PORT_W * NUM_BANKS;
    localparam int CNT_W   = PORT_W * 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PA   = 2'd0,
        SEL_PB   = 2'd1,
        SEL_PC   = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] pa;
        logic [PORT_W-1:0] pb;
        logic [PORT_W-1:0] pc;
        logic [PORT_W-1:0] ctrl;
    } bank_regs_t;
endpackage

// File: rtl/delay_port_bank.sv
module delay_port_bank
    import delay_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] wdata,
    output bank_regs_t        regs,
    output logic [PORT_W-1:0] rdata
);
    typedef struct packed {
        bank_regs_t regs;
    } bank_state_t;

    bank_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (sel)
                SEL_PA:   s_d.regs.pa   = wdata;
                SEL_PB:   s_d.regs.pb   = wdata;
                SEL_PC:   s_d.regs.pc   = wdata;
                default:  s_d.regs.ctrl = wdata;
            endcase
        end
        case (sel)
            SEL_PA:  rdata = s_q.regs.pa;
            SEL_PB:  rdata = s_q.regs.pb;
            SEL_PC:  rdata = s_q.regs.pc;
            default: rdata = s_q.regs.ctrl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign regs = s_q.regs;
endmodule

// File: rtl/delay_word_map.sv
module delay_word_map
    import delay_ctl_pkg::*;
(
    input  bank_regs_t        lo_regs,
    input  bank_regs_t        hi_regs,
    output logic [PORT_W-1:0] dac_code,
    output logic [CNT_W-1:0]  dly_count
);
    logic [CNT_W-1:0] raw_count;

    always_comb begin
        raw_count = {hi_regs.pb, hi_regs.pa, lo_regs.pb};
        dly_count = ~raw_count;
        dac_code  = ~lo_regs.pa;
    end
endmodule

// File: rtl/delay_halt_seq.sv
module delay_halt_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic sample_done,
    output logic halt
);
    typedef struct packed {
        logic halt;
    } halt_state_t;

    halt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.halt) begin
            if (sample_done) s_d.halt = 1'b0;
        end else if (trig_in) begin
            s_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign halt = s_q.halt;
endmodule

// File: rtl/delay_ctl_if.sv
module delay_ctl_if
    import delay_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_lbe,
    input  logic              bus_ube,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              trig_in,
    input  logic              sample_done,
    output logic [PORT_W-1:0] dac_code,
    output logic [CNT_W-1:0]  dly_count,
    output logic              cpu_halt
);
    logic [NUM_BANKS-1:0] lane_en;
    bank_regs_t           bank_regs  [NUM_BANKS];
    logic [PORT_W-1:0]    bank_rdata [NUM_BANKS];
    reg_sel_e             sel;

    assign lane_en = {bus_ube, bus_lbe};
    assign sel     = reg_sel_e'(bus_addr);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic lane_wr;
        assign lane_wr = bus_sel && bus_wr && lane_en[b];

        delay_port_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (lane_wr),
            .sel   (sel),
            .wdata (bus_wdata[b*PORT_W +: PORT_W]),
            .regs  (bank_regs[b]),
            .rdata (bank_rdata[b])
        );

        assign bus_rdata[b*PORT_W +: PORT_W] =
            (bus_sel && bus_rd && lane_en[b]) ? bank_rdata[b] : '0;
    end

    delay_word_map u_map (
        .lo_regs   (bank_regs[0]),
        .hi_regs   (bank_regs[1]),
        .dac_code  (dac_code),
        .dly_count (dly_count)
    );

    delay_halt_seq u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .sample_done (sample_done),
        .halt        (cpu_halt)
    );
endmodule

// File: rtl/delay_ctl_chk.sv
module delay_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic        bus_lbe,
    input logic        bus_ube,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        trig_in,
    input logic        sample_done,
    input logic [7:0]  dac_code,
    input logic [23:0] dly_count,
    input logic        cpu_halt
);
    a_r10_halt_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt && trig_in) |=> cpu_halt);

    a_r11_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !sample_done) |=> cpu_halt);

    a_r11_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && sample_done) |=> !cpu_halt);

    a_r10_no_spurious_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt && !trig_in) |=> !cpu_halt);

    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && (bus_lbe || bus_ube)) |=> ($stable(dac_code) && $stable(dly_count)));

    a_r7_dac_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_lbe && bus_addr == 2'd0) |=> dac_code == ~$past(bus_wdata[7:0]));

    a_r8_count_top: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_ube && bus_addr == 2'd1) |=> dly_count[23:16] == ~$past(bus_wdata[15:8]));
endmodule

bind delay_ctl_if delay_ctl_chk u_chk (.*);

// File: tb/delay_ctl_if_tb.sv
module delay_ctl_if_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_rd = 0, bus_wr = 0, bus_lbe = 0, bus_ube = 0;
    logic [1:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        trig_in = 0, sample_done = 0;
    logic [7:0]  dac_code;
    logic [23:0] dly_count;
    logic        cpu_halt;

    int tests = 0, fails = 0;
    logic [7:0] m_lo [4];
    logic [7:0] m_hi [4];

    always #4 clk = ~clk;

    delay_ctl_if u_dut (.*);

    function automatic logic [7:0] exp_dac();
        return ~m_lo[0];
    endfunction

    function automatic logic [23:0] exp_cnt();
        return ~{m_hi[1], m_hi[0], m_lo[1]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req);
        chk(dac_code == exp_dac(), req, {24'd0, dac_code}, {24'd0, exp_dac()});
        chk(dly_count == exp_cnt(), req, {8'd0, dly_count}, {8'd0, exp_cnt()});
    endtask

    // Called at a negedge; one posedge passes, returns at the next negedge.
    task automatic bus_cycle(input bit s, input bit w, input bit lb, input bit ub,
                             input logic [1:0] a, input logic [15:0] d);
        bus_sel = s; bus_wr = w; bus_lbe = lb; bus_ube = ub; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        if (s && w && lb) m_lo[a] = d[7:0];
        if (s && w && ub) m_hi[a] = d[15:8];
        bus_sel = 0; bus_wr = 0; bus_lbe = 0; bus_ube = 0;
    endtask

    task automatic read_chk(input bit lb, input bit ub, input logic [1:0] a, input string req);
        logic [15:0] e;
        bus_sel = 1; bus_rd = 1; bus_lbe = lb; bus_ube = ub; bus_addr = a;
        #1;
        e = {ub ? m_hi[a] : 8'h00, lb ? m_lo[a] : 8'h00};
        chk(bus_rdata == e, req, {16'd0, bus_rdata}, {16'd0, e});
        bus_sel = 0; bus_rd = 0; bus_lbe = 0; bus_ube = 0;
        #1;
        chk(bus_rdata == 16'h0, req, {16'd0, bus_rdata}, 32'd0);
    endtask

    task automatic halt_step(input bit t, input bit d, input bit e, input string req);
        trig_in = t; sample_done = d;
        @(negedge clk);
        trig_in = 0; sample_done = 0;
        chk(cpu_halt == e, req, {31'd0, cpu_halt}, {31'd0, e});
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk_outs("R1");
        chk(dly_count == 24'hFFFFFF, "R1", {8'd0, dly_count}, 32'hFFFFFF);
        chk(cpu_halt == 0, "R1", {31'd0, cpu_halt}, 0);
        for (int a = 0; a < 4; a++) read_chk(1, 1, 2'(a), "R1");

        // R2 / R7 lower port A, zero gives maximum delay
        bus_cycle(1, 1, 1, 0, 2'd0, 16'hAB00);
        chk(dac_code == 8'hFF, "R7", {24'd0, dac_code}, 32'hFF);
        bus_cycle(1, 1, 1, 0, 2'd0, 16'hEE5A);
        chk(dac_code == 8'hA5, "R7", {24'd0, dac_code}, 32'hA5);
        chk_outs("R2");
        read_chk(1, 0, 2'd0, "R2");

        // R3 upper only, lower B untouched
        bus_cycle(1, 1, 0, 1, 2'd1, 16'h3C77);
        chk_outs("R3");
        chk(dly_count[7:0] == 8'hFF, "R3", {24'd0, dly_count[7:0]}, 32'hFF);
        read_chk(1, 1, 2'd1, "R3");

        // R4 both strobes
        bus_cycle(1, 1, 1, 1, 2'd1, 16'h1281);
        chk(dly_count == ~{8'h12, 8'h00, 8'h81}, "R4", {8'd0, dly_count}, {8'd0, ~{8'h12, 8'h00, 8'h81}});
        bus_cycle(1, 1, 1, 1, 2'd0, 16'h4400);
        chk_outs("R4");

        // R9 control and port C
        bus_cycle(1, 1, 1, 1, 2'd3, 16'hC39B);
        chk_outs("R9");
        read_chk(1, 1, 2'd3, "R9");
        bus_cycle(1, 1, 1, 1, 2'd2, 16'h6699);
        chk_outs("R9");
        read_chk(1, 1, 2'd2, "R9");

        // R5 missing select, write or strobe
        bus_cycle(0, 1, 1, 1, 2'd0, 16'h1111);
        bus_cycle(1, 0, 1, 1, 2'd1, 16'h2222);
        bus_cycle(1, 1, 0, 0, 2'd0, 16'h3333);
        chk_outs("R5");
        for (int a = 0; a < 4; a++) read_chk(1, 1, 2'(a), "R5");

        // R6 lane routing
        read_chk(0, 1, 2'd0, "R6");
        read_chk(1, 0, 2'd1, "R6");
        read_chk(0, 0, 2'd3, "R6");

        // R10 / R11 halt sequencing
        halt_step(0, 1, 0, "R11");
        halt_step(1, 0, 1, "R10");
        halt_step(1, 0, 1, "R11");
        halt_step(0, 0, 1, "R11");
        halt_step(0, 1, 0, "R11");
        halt_step(1, 1, 1, "R10");
        halt_step(1, 1, 0, "R11");

        // Random traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [3:0] ctl;
            ctl = 4'($urandom);
            bus_cycle(($urandom % 4) != 0, ctl[0] | ctl[1], ctl[2], ctl[3],
                      2'($urandom), 16'($urandom));
            chk_outs("R8");
            read_chk(1'($urandom), 1'($urandom), 2'($urandom), "R6");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule